// File: doc/BRIEF.md
# Raster Position Interrupt Generator

This block watches the live horizontal and vertical position of a raster timing generator and raises an interrupt request when the position satisfies the trigger pattern picked by a 3-bit mode field. The compare values it uses are the active (already latched) copies held by the timing generator. A value written by software but not yet taken over has no influence here.

The patterns are:
- a single point once per frame;
- every pixel of one selected line;
- an inclusive H range on that selected line;
- a one-shot window over the picture area;
- the single point together with the picture window, also one-shot;
- silence.

The one-shot patterns disarm themselves when the picture window has been scanned to its last pixel. They stay quiet until software pulses either of two acknowledge bits. The request is a registered one-clock pulse for every matching pixel position. It goes to an interrupt controller outside this block.

Top module: `raster_irq_gen`

## Requirements
- R1: While reset is asserted, `irq` is 0. After reset the one-shot logic is armed.
- R2: Mode 5 pulses `irq` exactly once per frame, at position V=`pt_v`, H=`pt_h`.
- R3: Mode 6 pulses `irq` at every H position of the line V=`line_v`.
- R4: Mode 4 pulses `irq` on the line V=`line_v` for every H with `win_h_lo` <= H <= `win_h_hi`. When `win_h_lo` > `win_h_hi` it never pulses.
- R5: Mode 3, while armed, pulses at every H with `pic_h_lo` <= H <= `pic_h_hi` on the line V=`pic_v`. Reaching H=`pic_h_hi` on that line disarms it, and it then stays silent until re-armed.
- R6: A cycle with `ack_bits` not equal to 2'b00 (bit 0 or bit 1 high) arms the one-shot logic from the next cycle on.
- R7: Mode 1, while armed, pulses at the mode 5 point and over the mode 3 window. Only completing the window disarms it.
- R8: Mode codes 0, 2 and 7 never produce a pulse.
- R9: With `disp_en` at 0, no mode produces a pulse, and the one-shot state is left unchanged.
- R10: If `line_v` holds a value the V counter never reaches (such as all ones), modes 6 and 4 stay silent.
- R11: Each pulse appears in the clock cycle after the one in which the position inputs matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display enable; 0 blocks all requests |
| irq_mode | input | 3 | Trigger mode code |
| ack_bits | input | 2 | Acknowledge/re-arm strobes; either bit re-arms |
| h_pos | input | CW | Live horizontal position |
| v_pos | input | CW | Live vertical position |
| pt_v | input | CW | Single-point line |
| pt_h | input | CW | Single-point column |
| line_v | input | CW | Selected line for modes 4 and 6 |
| win_h_lo | input | CW | Mode 4 first column |
| win_h_hi | input | CW | Mode 4 last column |
| pic_v | input | CW | Picture-window line |
| pic_h_lo | input | CW | Picture-window first column |
| pic_h_hi | input | CW | Picture-window last column |
| irq | output | 1 | One-clock interrupt request pulse |

## Verification
The only hidden state is the armed flag. A wrong value shows up at `irq` no later than the next scan of the picture line in mode 1 or 3. A missing or extra window is seen within one frame of the re-arm strobe. Comparator or decode errors appear on the first pixel where the pattern should start or stop. Because every pixel of several frames is compared, a one-column slip in a range end or a one-cycle latency error is caught at once.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

  typedef enum logic [2:0] {
    RM_RSV0  = 3'd0,
    RM_COMBO = 3'd1,
    RM_RSV2  = 3'd2,
    RM_PICT  = 3'd3,
    RM_RANGE = 3'd4,
    RM_POINT = 3'd5,
    RM_LINE  = 3'd6,
    RM_OFF   = 3'd7
  } rirq_mode_e;

  typedef struct packed {
    logic point;
    logic line;
    logic range;
    logic pict;
    logic oneshot;
  } rirq_sel_t;

  localparam int unsigned NUM_SPANS = 4;

endpackage

// File: rtl/rirq_mode_dec.sv
module rirq_mode_dec
  import rirq_pkg::*;
(
  input  logic       disp_en,
  input  logic [2:0] mode,
  output rirq_sel_t  sel
);

  rirq_mode_e mode_e;

  assign mode_e = rirq_mode_e'(mode);

  always_comb begin
    sel = '0;
    if (disp_en) begin
      unique case (mode_e)
        RM_POINT: sel.point = 1'b1;
        RM_LINE:  sel.line  = 1'b1;
        RM_RANGE: sel.range = 1'b1;
        RM_PICT: begin
          sel.pict    = 1'b1;
          sel.oneshot = 1'b1;
        end
        RM_COMBO: begin
          sel.point   = 1'b1;
          sel.pict    = 1'b1;
          sel.oneshot = 1'b1;
        end
        default: sel = '0;
      endcase
    end
  end

endmodule

// File: rtl/rirq_span.sv
module rirq_span #(
  parameter int unsigned CW = 12
) (
  input  logic [CW-1:0] h_pos,
  input  logic [CW-1:0] v_pos,
  input  logic [CW-1:0] line,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          hit
);

  logic on_line;
  logic past_lo;
  logic before_hi;

  always_comb begin
    on_line   = (v_pos == line);
    past_lo   = (h_pos >= lo);
    before_hi = (h_pos <= hi);
    hit       = on_line & past_lo & before_hi;
  end

endmodule

// File: rtl/rirq_oneshot.sv
module rirq_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic done,
  output logic armed
);

  logic armed_q;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_en = rearm | done;
    armed_d  = rearm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  // R5: once disarmed, only a strobe brings it back
  p_stay_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rearm) |=> !armed_q);

  // R6: a strobe always leaves the flag set
  p_rearm_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> armed_q);

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import rirq_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_en,
  input  logic [2:0]    irq_mode,
  input  logic [1:0]    ack_bits,
  input  logic [CW-1:0] h_pos,
  input  logic [CW-1:0] v_pos,
  input  logic [CW-1:0] pt_v,
  input  logic [CW-1:0] pt_h,
  input  logic [CW-1:0] line_v,
  input  logic [CW-1:0] win_h_lo,
  input  logic [CW-1:0] win_h_hi,
  input  logic [CW-1:0] pic_v,
  input  logic [CW-1:0] pic_h_lo,
  input  logic [CW-1:0] pic_h_hi,
  output logic          irq
);

  localparam logic [CW-1:0] H_FIRST = '0;
  localparam logic [CW-1:0] H_LAST  = '1;
  localparam int unsigned   SP_PT   = 0;
  localparam int unsigned   SP_LN   = 1;
  localparam int unsigned   SP_RG   = 2;
  localparam int unsigned   SP_PC   = 3;

  rirq_sel_t sel;
  logic [CW-1:0] sp_line [NUM_SPANS];
  logic [CW-1:0] sp_lo   [NUM_SPANS];
  logic [CW-1:0] sp_hi   [NUM_SPANS];
  logic [NUM_SPANS-1:0] hit;
  logic armed;
  logic rearm;
  logic pic_end;
  logic win_done;
  logic pt_gate;
  logic irq_d;
  logic irq_q;

  rirq_mode_dec i_dec (
    .disp_en (disp_en),
    .mode    (irq_mode),
    .sel     (sel)
  );

  assign sp_line[SP_PT] = pt_v;
  assign sp_lo[SP_PT]   = pt_h;
  assign sp_hi[SP_PT]   = pt_h;
  assign sp_line[SP_LN] = line_v;
  assign sp_lo[SP_LN]   = H_FIRST;
  assign sp_hi[SP_LN]   = H_LAST;
  assign sp_line[SP_RG] = line_v;
  assign sp_lo[SP_RG]   = win_h_lo;
  assign sp_hi[SP_RG]   = win_h_hi;
  assign sp_line[SP_PC] = pic_v;
  assign sp_lo[SP_PC]   = pic_h_lo;
  assign sp_hi[SP_PC]   = pic_h_hi;

  for (genvar g = 0; g < NUM_SPANS; g++) begin : g_span
    rirq_span #(.CW(CW)) i_span (
      .h_pos (h_pos),
      .v_pos (v_pos),
      .line  (sp_line[g]),
      .lo    (sp_lo[g]),
      .hi    (sp_hi[g]),
      .hit   (hit[g])
    );
  end

  always_comb begin
    rearm    = |ack_bits;
    pic_end  = hit[SP_PC] & (h_pos == pic_h_hi);
    win_done = sel.oneshot & armed & pic_end;
    pt_gate  = sel.oneshot ? armed : 1'b1;
    irq_d    = (sel.point & hit[SP_PT] & pt_gate)
             | (sel.line  & hit[SP_LN])
             | (sel.range & hit[SP_RG])
             | (sel.pict  & hit[SP_PC] & armed);
  end

  rirq_oneshot i_oneshot (
    .clk   (clk),
    .rst_n (rst_n),
    .rearm (rearm),
    .done  (win_done),
    .armed (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R9: no request unless the display was enabled a cycle earlier
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(disp_en));

  // R8: reserved and off codes stay silent
  p_rsv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !($past(irq_mode) inside {3'd0, 3'd2, 3'd7}));

  // R2: frame point pulses only at the programmed position
  p_point_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && $past(irq_mode) == 3'd5)
      |-> ($past(v_pos) == $past(pt_v) && $past(h_pos) == $past(pt_h)));

  // R3: whole-line pulses only on the selected line
  p_line_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && $past(irq_mode) == 3'd6) |-> ($past(v_pos) == $past(line_v)));

  // R1: request low while reset is held
  always_comb begin
    if (!rst_n) begin
      p_reset_low_r1: assert (irq_q == 1'b0);
    end
  end

endmodule

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;

  localparam int CW    = 6;
  localparam int H_TOT = 12;
  localparam int V_TOT = 8;
  localparam int PT_V  = 5;
  localparam int PT_H  = 10;
  localparam int PIC_V = 2;
  localparam int PIC_L = 1;
  localparam int PIC_H = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          disp_en;
  logic [2:0]    irq_mode;
  logic [1:0]    ack_bits;
  logic [CW-1:0] h_pos, v_pos, line_v, win_h_lo, win_h_hi;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit m_armed;
  bit exp_irq;
  string prev_tag;

  always #5 clk = ~clk;

  raster_irq_gen #(.CW(CW)) i_raster_irq_gen (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .irq_mode(irq_mode),
    .ack_bits(ack_bits), .h_pos(h_pos), .v_pos(v_pos),
    .pt_v(CW'(PT_V)), .pt_h(CW'(PT_H)), .line_v(line_v),
    .win_h_lo(win_h_lo), .win_h_hi(win_h_hi),
    .pic_v(CW'(PIC_V)), .pic_h_lo(CW'(PIC_L)), .pic_h_hi(CW'(PIC_H)),
    .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model(input int m, input bit en, input int h, input int v);
    bit pt, ln, rg, pc;
    pt = (v == PT_V) && (h == PT_H);
    ln = (v == int'(line_v));
    rg = ln && (h >= int'(win_h_lo)) && (h <= int'(win_h_hi));
    pc = (v == PIC_V) && (h >= PIC_L) && (h <= PIC_H);
    if (!en) return 1'b0;
    case (m)
      5: return pt;
      6: return ln;
      4: return rg;
      3: return m_armed && pc;
      1: return m_armed && (pt || pc);
      default: return 1'b0;
    endcase
  endfunction

  // Scan whole frames; irq seen at a negedge belongs to inputs of the previous cycle (R11)
  task automatic run(input int m, input bit en, input int frames,
                     input int rf, input int rl, input logic [1:0] ack_pat,
                     input string tag, input int exp_cnt);
    int cnt = 0;
    bit first = 1'b1;
    for (int f = 0; f < frames; f++) begin
      for (int v = 0; v < V_TOT; v++) begin
        for (int h = 0; h < H_TOT; h++) begin
          @(negedge clk);
          check({prev_tag, " R11"}, irq, exp_irq);
          if (!first && irq) cnt++;
          first = 1'b0;
          disp_en  = en;
          irq_mode = 3'(m);
          h_pos    = CW'(h);
          v_pos    = CW'(v);
          ack_bits = (f == rf && v == rl && h == 0) ? ack_pat : 2'b00;
          exp_irq  = model(m, en, h, v);
          if (ack_bits != 2'b00) m_armed = 1'b1;
          else if (en && (m == 1 || m == 3) && m_armed && v == PIC_V && h == PIC_H)
            m_armed = 1'b0;
          prev_tag = tag;
        end
      end
    end
    @(negedge clk);
    check({prev_tag, " R11"}, irq, exp_irq);
    if (irq) cnt++;
    check({tag, " pulse count"}, cnt, exp_cnt);
    disp_en  = 1'b0;
    irq_mode = 3'd7;
    ack_bits = 2'b00;
    exp_irq  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; disp_en = 1'b0; irq_mode = 3'd7; ack_bits = 2'b00;
    h_pos = '0; v_pos = '0; line_v = CW'(3); win_h_lo = CW'(4); win_h_hi = CW'(7);
    m_armed = 1'b1; exp_irq = 1'b0; prev_tag = "R1";
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    // R8 reserved and off codes
    run(0, 1, 2, -1, 0, 2'b00, "R8 mode0", 0);
    run(2, 1, 2, -1, 0, 2'b00, "R8 mode2", 0);
    run(7, 1, 2, -1, 0, 2'b00, "R8 mode7", 0);
    // R9 display disabled; one-shot must stay armed
    run(5, 0, 1, -1, 0, 2'b00, "R9 mode5 off", 0);
    run(6, 0, 1, -1, 0, 2'b00, "R9 mode6 off", 0);
    run(3, 0, 1, -1, 0, 2'b00, "R9 mode3 off", 0);
    run(5, 1, 2, -1, 0, 2'b00, "R2 point", 2);
    run(6, 1, 2, -1, 0, 2'b00, "R3 line", 2 * H_TOT);
    run(4, 1, 2, -1, 0, 2'b00, "R4 range", 2 * 4);
    win_h_lo = CW'(8); win_h_hi = CW'(4);
    run(4, 1, 1, -1, 0, 2'b00, "R4 empty range", 0);
    win_h_lo = CW'(4); win_h_hi = CW'(7);
    line_v = '1;
    run(6, 1, 2, -1, 0, 2'b00, "R10 line6 unreachable", 0);
    run(4, 1, 1, -1, 0, 2'b00, "R10 range unreachable", 0);
    line_v = CW'(3);
    // R5/R1: armed from reset, window once, silent, re-armed by bit0 (R6)
    run(3, 1, 3, 2, 0, 2'b01, "R5 R6 R1 picture", 2 * (PIC_H - PIC_L + 1));
    // R7: disarmed frame, re-arm by bit1 before point line (R6), then window
    run(1, 1, 3, 1, 4, 2'b10, "R7 R6 combo", 1 + (PIC_H - PIC_L + 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule